// File: doc/BRIEF.md
# Packed 32-bit Integer Vector Execution Unit

This unit runs integer vector operations on 256-bit operands. Each operand is split into eight 32-bit lanes that never interact arithmetically. There are four operations. Add sums the lanes pairwise. Multiply keeps the low 32 bits of each lane product. Broadcast copies one 32-bit scalar into every lane. Permute treats operand A as four 64-bit quadwords and rearranges them under an 8-bit immediate.

A narrow mode runs the same operations on the low 128 bits only. In narrow mode the unit ignores the upper half of each operand and drives the upper half of the result to zero.

Each accepted operation produces a registered result on the next cycle, marked by an output valid strobe. Between operations the result register keeps its last value.

Top module: `simd_unit`

## Requirements
- R1: With `op` = 0 (add), result lane j equals (A lane j + B lane j) mod 2^32, for each j. Lane j occupies bits [32j+31:32j]. A carry out of one lane never reaches the next lane.
- R2: With `op` = 1 (multiply), result lane j equals the low 32 bits of the unsigned product of A lane j and B lane j.
- R3: With `op` = 2 (broadcast), every active lane of the result equals `scalar`, and operands A and B have no effect.
- R4: With `op` = 3 (permute), result quadword i (bits [64i+63:64i]) equals the quadword of A whose index is `imm`[2i+1:2i]. For example, A quadwords {1,2,3,4} with `imm` = 8'h4E give {3,4,1,2}.
- R5: When `narrow` = 1, only lanes 0 to 3 are active. Result bits [255:128] are zero, and bits [255:128] of A and B are treated as zero. As a result, a permute index of 2 or 3 yields a zero quadword.
- R6: Opcodes 4 to 7 are undefined. They give an all-zero result, and `out_valid` is still asserted.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low otherwise.
- R8: While `in_valid` is low, `result` keeps its previous value.
- R9: While reset is asserted, `out_valid` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Opcode: 0 add, 1 multiply, 2 broadcast, 3 permute |
| narrow | input | 1 | 128-bit mode |
| imm | input | 8 | Permute selectors, 2 bits per output quadword |
| src_a | input | 256 | Operand A |
| src_b | input | 256 | Operand B |
| scalar | input | 32 | Broadcast value |
| out_valid | output | 1 | Result strobe |
| result | output | 256 | Registered result |

## Verification
All per-operation state sits in a single result register that is loaded on the edge after `in_valid`. A wrong lane function, a mis-steered permute selector or a leaked upper half therefore shows up in `result` exactly one cycle after the offending input, and no later. A mis-gated clock enable appears as a changed `result` during an idle cycle. A broken valid pipeline appears as a missing or extra `out_valid` pulse. The bench sweeps every opcode in both widths with varied data, including operands that force a carry across lane edges. It also sweeps all 256 permute immediates in both widths.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int unsigned LANE_W = 32;
  localparam int unsigned QWORD_W = 64;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MUL   = 3'd1,
    OP_BCAST = 3'd2,
    OP_PERM  = 3'd3
  } simd_op_e;
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
(
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic [LANE_W-1:0] scalar_i,
  input  logic [2:0]        op_i,
  input  logic              active_i,
  output logic [LANE_W-1:0] y_o
);
  logic [LANE_W-1:0] sum, prod;

  always_comb begin
    sum  = a_i + b_i;
    prod = a_i * b_i;
    y_o  = '0;
    if (active_i) begin
      unique case (op_i)
        OP_ADD:   y_o = sum;
        OP_MUL:   y_o = prod;
        OP_BCAST: y_o = scalar_i;
        default:  y_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/simd_qperm.sv
module simd_qperm
  import simd_pkg::*;
#(
  parameter int unsigned QWORDS = 4,
  localparam int unsigned SEL_W = $clog2(QWORDS),
  localparam int unsigned VEC_W = QWORDS * QWORD_W
) (
  input  logic [VEC_W-1:0]        vec_i,
  input  logic [QWORDS*SEL_W-1:0] sel_i,
  output logic [VEC_W-1:0]        vec_o
);
  for (genvar q = 0; q < QWORDS; q++) begin : g_q
    logic [SEL_W-1:0] idx;
    assign idx = sel_i[q*SEL_W +: SEL_W];
    assign vec_o[q*QWORD_W +: QWORD_W] = vec_i[idx*QWORD_W +: QWORD_W];
  end
endmodule

// File: rtl/simd_unit.sv
module simd_unit
  import simd_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned VEC_W = LANES * LANE_W,
  localparam int unsigned QWORDS = VEC_W / QWORD_W,
  localparam int unsigned IMM_W = QWORDS * $clog2(QWORDS),
  localparam int unsigned HALF = LANES / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              narrow,
  input  logic [IMM_W-1:0]  imm,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [LANE_W-1:0] scalar,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result
);
  logic [VEC_W-1:0] a_eff, b_eff, lane_res, perm_raw, perm_res, res_next;
  logic [LANES-1:0] lane_act;

  // Lane activity and operand masking for narrow mode
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign lane_act[j] = !(narrow && (j >= HALF));
    assign a_eff[j*LANE_W +: LANE_W] = lane_act[j] ? src_a[j*LANE_W +: LANE_W] : '0;
    assign b_eff[j*LANE_W +: LANE_W] = lane_act[j] ? src_b[j*LANE_W +: LANE_W] : '0;

    simd_lane u_lane (
      .a_i      (a_eff[j*LANE_W +: LANE_W]),
      .b_i      (b_eff[j*LANE_W +: LANE_W]),
      .scalar_i (scalar),
      .op_i     (op),
      .active_i (lane_act[j]),
      .y_o      (lane_res[j*LANE_W +: LANE_W])
    );

    assign perm_res[j*LANE_W +: LANE_W] = lane_act[j] ? perm_raw[j*LANE_W +: LANE_W] : '0;
  end

  simd_qperm #(.QWORDS(QWORDS)) u_qperm (
    .vec_i (a_eff),
    .sel_i (imm),
    .vec_o (perm_raw)
  );

  // Next-state selection
  always_comb begin
    unique case (op)
      OP_ADD, OP_MUL, OP_BCAST: res_next = lane_res;
      OP_PERM:                  res_next = perm_res;
      default:                  res_next = '0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_next;
    end
  end
endmodule

// File: rtl/simd_unit_chk.sv
module simd_unit_chk #(
  parameter int unsigned LANES = 8,
  localparam int unsigned VEC_W = LANES * 32,
  localparam int unsigned IMM_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        op,
  input logic              narrow,
  input logic [IMM_W-1:0]  imm,
  input logic [VEC_W-1:0]  src_a,
  input logic [VEC_W-1:0]  src_b,
  input logic [31:0]       scalar,
  input logic              out_valid,
  input logic [VEC_W-1:0]  result
);
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && narrow) |=> (result[VEC_W-1:VEC_W/2] == '0));
  a_r6_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[2]) |=> (result == '0));
  a_r3_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2 && !narrow) |=> (result == {LANES{$past(scalar)}}));
endmodule

bind simd_unit simd_unit_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
  .imm(imm), .src_a(src_a), .src_b(src_b), .scalar(scalar),
  .out_valid(out_valid), .result(result)
);

// File: tb/test_simd_unit.sv
module test_simd_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   op;
  logic         narrow;
  logic [7:0]   imm;
  logic [255:0] src_a, src_b;
  logic [31:0]  scalar;
  logic         out_valid;
  logic [255:0] result;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_unit i_simd_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .narrow(narrow),
    .imm(imm), .src_a(src_a), .src_b(src_b), .scalar(scalar),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [255:0] model(input logic [2:0] o, input logic nw,
      input logic [7:0] im, input logic [255:0] a, input logic [255:0] b,
      input logic [31:0] s);
    logic [255:0] y = '0;
    logic [255:0] am = a, bm = b;
    int nl = nw ? 4 : 8;
    logic [63:0] pr;
    if (nw) begin am[255:128] = '0; bm[255:128] = '0; end
    for (int j = 0; j < nl; j++) begin
      case (o)
        3'd0: y[j*32 +: 32] = 32'((64'(am[j*32 +: 32]) + 64'(bm[j*32 +: 32])) % 64'h1_0000_0000);
        3'd1: begin
          pr = 64'(am[j*32 +: 32]) * 64'(bm[j*32 +: 32]);
          y[j*32 +: 32] = pr[31:0];
        end
        3'd2: y[j*32 +: 32] = s;
        default: ;
      endcase
    end
    if (o == 3'd3)
      for (int q = 0; q < nl/2; q++) y[q*64 +: 64] = am[int'(im[2*q +: 2])*64 +: 64];
    return y;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [2:0] o, input logic nw,
      input logic [7:0] im, input logic [255:0] a, input logic [255:0] b,
      input logic [31:0] s);
    logic [255:0] exp;
    @(negedge clk);
    in_valid = 1'b1; op = o; narrow = nw; imm = im; src_a = a; src_b = b; scalar = s;
    exp = model(o, nw, im, a, b, s);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", {255'd0, out_valid}, 256'd1);
    check(req, result, exp);
    src_a = rnd256(); src_b = rnd256(); scalar = $urandom; op = 3'($urandom);
    @(negedge clk);
    check("R7", {255'd0, out_valid}, 256'd0);
    check("R8", result, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op = '0; narrow = 1'b0; imm = '0;
    src_a = '0; src_b = '0; scalar = '0;
    repeat (3) @(negedge clk);
    check("R9", {255'd0, out_valid}, 256'd0);
    check("R9", result, 256'd0);
    rst_n = 1'b1;

    // R1: carries across lane edges must not propagate
    apply("R1", 3'd0, 1'b0, 8'h00, {8{32'hFFFF_FFFF}}, {8{32'h0000_0001}}, 32'h0);
    apply("R1", 3'd0, 1'b0, 8'h00, {8{32'h8000_0000}}, {8{32'h8000_0000}}, 32'h0);
    // R2: product overflow, keep low half
    apply("R2", 3'd1, 1'b0, 8'h00, {8{32'hFFFF_FFFF}}, {8{32'hFFFF_FFFF}}, 32'h0);
    apply("R2", 3'd1, 1'b0, 8'h00, {8{32'h0001_0000}}, {8{32'h0001_0003}}, 32'h0);
    // R4: worked example, quadwords {1,2,3,4} -> {3,4,1,2}
    apply("R4", 3'd3, 1'b0, 8'h4E, {64'd4, 64'd3, 64'd2, 64'd1}, '0, 32'h0);

    // Sweep all opcodes in both widths with random data
    for (int rep = 0; rep < 20; rep++)
      for (int o = 0; o < 8; o++)
        for (int w = 0; w < 2; w++)
          apply(o == 0 ? (w ? "R5" : "R1") : o == 1 ? (w ? "R5" : "R2") :
                o == 2 ? (w ? "R5" : "R3") : o == 3 ? (w ? "R5" : "R4") : "R6",
                3'(o), 1'(w), 8'($urandom), rnd256(), rnd256(), $urandom);

    // R4/R5: every permute immediate in both widths
    for (int im = 0; im < 256; im++)
      for (int w = 0; w < 2; w++)
        apply(w ? "R5" : "R4", 3'd3, 1'(w), 8'(im), rnd256(), rnd256(), $urandom);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule